// File: doc/BRIEF.md
# Serial Controller Host Register and Interrupt Unit

This block is the byte-wide register face of a 16450-class serial controller. A host reaches eight registers through a 3-bit address, one access per cycle. The registers cover line configuration, a 16-bit baud divisor, interrupt enables and identification, modem control, line and modem status, and a scratch byte. Bit timing is left to an external serial framer. The framer receives the line configuration and the divisor as plain output pins. Transmit bytes go to it, and received bytes come back from it, over valid/ready handshakes.

Back-pressure rules are as follows. A written transmit byte stays on `tx_data` with `tx_valid` high until a cycle in which `tx_ready` is high. The holding register counts as empty only after that cycle. On the receive side, `rx_ready` is high only while no unread byte is held and no break is being reported. The framer must keep its byte on `rx_data` until it sees `rx_ready`. A break is a plain one-cycle pulse that is never refused.

An access is a cycle with `bus_sel` high. Read data is combinational in that same cycle. Every state change, including the side effects of a read, takes place at the closing clock edge.

Top module: `sio_regblock`

## Requirements
- R1: When line-control bit 7 is set, addresses 0 and 1 write and read the low and high divisor bytes, which appear on `divisor`. Such writes start no transmission, and such reads have no side effect. Line control (address 3) reads back all 8 bits and drives `line_ctrl`.
- R2: Interrupt enable (address 1, bit 7 clear) keeps only bits 3:0 and reads back zeros above them. Writing it while the holding register is empty (status bit 5) sets the hidden transmit-empty pending flag.
- R3: Identification (address 2) reads 0x04 when data is ready and enable bit 0 is set. Otherwise it reads 0x02 when the transmit-empty flag is pending and enable bit 1 is set. Otherwise it reads 0x01.
- R4: `irq` is high exactly when identification differs from 0x01.
- R5: Reading identification while it shows 0x02 clears the pending flag. The next read gives 0x01 unless a receive interrupt applies.
- R6: A received byte is taken only in a cycle with `rx_valid` and `rx_ready` both high, and `rx_ready` is high only while DR (status bit 0) is clear. Taking a byte loads the receive register and sets DR. A byte offered while DR is set leaves the held byte unchanged.
- R7: Reading address 0 with line-control bit 7 clear returns the held byte and clears DR and BI (status bits 0 and 4).
- R8: A `rx_brk` pulse loads the receive register with 0x00 and sets both BI and DR, so line status reads 0x71 when the transmitter is idle.
- R9: Modem control (address 4) keeps bits 4:0. With bit 4 set, modem status reads control bit 3 on bit 7, bit 2 on bit 6, bit 0 on bit 5 and bit 1 on bit 4, with bits 3:0 zero. With bit 4 clear it reads 0xB0.
- R10: After reset, line status reads 0x60, identification reads 0x01, modem status reads 0xB0, `irq` is low, `tx_valid` is low and `rx_ready` is high.
- R11: Writing address 0 with line-control bit 7 clear presents the byte on `tx_data` with `tx_valid` high, and clears THRE (bit 5), TEMT (bit 6) and the pending flag. The handshake cycle sets all three again and drops `tx_valid`.
- R12: Address 7 is a plain read/write byte. Writes to addresses 2, 5 and 6 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Framer takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive register free |
| rx_data | input | 8 | Received byte |
| rx_brk | input | 1 | Break detected pulse |
| divisor | output | 16 | Baud divisor to the framer |
| line_ctrl | output | 8 | Line configuration to the framer |
| modem_ctrl | output | 5 | Modem control outputs |

## Verification
Read data is due in the access cycle itself, so the bench drives each access just after a falling edge and samples `bus_rdata` one time step later, before the rising edge. Every register update, including the clearing that a read causes, is due one edge after the access. The same holds for the effects of a transmit handshake, a received byte and a break. The bench therefore checks `tx_valid`, `rx_ready`, `irq` and status read-back at the next falling edge or through a later read. Sweeps cover all scratch values, all modem-control values and all enable nibbles, with each expected value computed from the bit rules above.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DIV_W  = 2 * BYTE_W;
  localparam int unsigned IEN_W  = 4;
  localparam int unsigned MCTL_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA  = 3'd0,
    A_IEN   = 3'd1,
    A_IDENT = 3'd2,
    A_LCTL  = 3'd3,
    A_MCTL  = 3'd4,
    A_LSTAT = 3'd5,
    A_MSTAT = 3'd6,
    A_SCR   = 3'd7
  } reg_addr_e;

  localparam logic [BYTE_W-1:0] ID_NONE = 8'h01;
  localparam logic [BYTE_W-1:0] ID_TXE  = 8'h02;
  localparam logic [BYTE_W-1:0] ID_RXD  = 8'h04;
  localparam logic [BYTE_W-1:0] MSTAT_IDLE = 8'hB0;
  localparam int unsigned LCTL_DIVSEL = 7;
  localparam int unsigned MCTL_LOOP   = 4;
endpackage

// File: rtl/sio_tx_hold.sv
module sio_tx_hold
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ien_wr,
  input  logic              ident_rd_txe,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              thre,
  output logic              temt,
  output logic              txe_pend
);
  logic hs;
  assign hs = tx_valid & tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      thre     <= 1'b1;
      temt     <= 1'b1;
      txe_pend <= 1'b0;
    end else if (thr_wr) begin
      tx_data  <= wdata;
      tx_valid <= 1'b1;
      thre     <= 1'b0;
      temt     <= 1'b0;
      txe_pend <= 1'b0;
    end else if (hs) begin
      tx_valid <= 1'b0;
      thre     <= 1'b1;
      temt     <= 1'b1;
      txe_pend <= 1'b1;
    end else if (ien_wr && thre) begin
      txe_pend <= 1'b1;
    end else if (ident_rd_txe) begin
      txe_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_brk,
  input  logic              rbr_rd,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] rbr,
  output logic              dr,
  output logic              bi
);
  assign rx_ready = ~dr & ~rx_brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr <= '0;
      dr  <= 1'b0;
      bi  <= 1'b0;
    end else if (rx_brk) begin
      rbr <= '0;
      dr  <= 1'b1;
      bi  <= 1'b1;
    end else if (rx_valid && rx_ready) begin
      rbr <= rx_data;
      dr  <= 1'b1;
    end else if (rbr_rd) begin
      dr  <= 1'b0;
      bi  <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_int_prio.sv
module sio_int_prio
  import sio_pkg::*;
(
  input  logic [IEN_W-1:0]  ien,
  input  logic              dr,
  input  logic              txe_pend,
  output logic [BYTE_W-1:0] ident,
  output logic              irq
);
  always_comb begin
    if (dr && ien[0])            ident = ID_RXD;
    else if (txe_pend && ien[1]) ident = ID_TXE;
    else                         ident = ID_NONE;
  end
  assign irq = (ident != ID_NONE);
endmodule

// File: rtl/sio_regblock.sv
module sio_regblock
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_brk,
  output logic [15:0]       divisor,
  output logic [7:0]        line_ctrl,
  output logic [4:0]        modem_ctrl
);
  logic [IEN_W-1:0]  ien_q;
  logic [BYTE_W-1:0] lctl_q, scr_q;
  logic [MCTL_W-1:0] mctl_q;
  logic [DIV_W-1:0]  div_q;
  logic              divsel;
  logic              wr_en, rd_en;
  logic              thr_wr, ien_wr, rbr_rd, ident_rd_txe;
  logic              thre, temt, txe_pend, dr, bi;
  logic [BYTE_W-1:0] rbr, ident, lstat, mstat;

  assign divsel = lctl_q[LCTL_DIVSEL];
  assign wr_en  = bus_sel & bus_wr;
  assign rd_en  = bus_sel & ~bus_wr;

  assign thr_wr       = wr_en & (bus_addr == A_DATA) & ~divsel;
  assign ien_wr       = wr_en & (bus_addr == A_IEN) & ~divsel;
  assign rbr_rd       = rd_en & (bus_addr == A_DATA) & ~divsel;
  assign ident_rd_txe = rd_en & (bus_addr == A_IDENT) & (ident == ID_TXE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      lctl_q <= '0;
      mctl_q <= '0;
      scr_q  <= '0;
      div_q  <= '0;
    end else if (wr_en) begin
      unique case (bus_addr)
        A_DATA:  if (divsel) div_q[BYTE_W-1:0] <= bus_wdata;
        A_IEN:   if (divsel) div_q[DIV_W-1:BYTE_W] <= bus_wdata;
                 else        ien_q <= bus_wdata[IEN_W-1:0];
        A_LCTL:  lctl_q <= bus_wdata;
        A_MCTL:  mctl_q <= bus_wdata[MCTL_W-1:0];
        A_SCR:   scr_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  sio_tx_hold u_tx (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .wdata(bus_wdata),
    .ien_wr(ien_wr), .ident_rd_txe(ident_rd_txe), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .thre(thre), .temt(temt),
    .txe_pend(txe_pend)
  );

  sio_rx_hold u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_brk(rx_brk), .rbr_rd(rbr_rd), .rx_ready(rx_ready), .rbr(rbr),
    .dr(dr), .bi(bi)
  );

  sio_int_prio u_int (
    .ien(ien_q), .dr(dr), .txe_pend(txe_pend), .ident(ident), .irq(irq)
  );

  assign lstat = {1'b0, temt, thre, bi, 3'b000, dr};

  always_comb begin
    if (mctl_q[MCTL_LOOP])
      mstat = {mctl_q[3], mctl_q[2], mctl_q[0], mctl_q[1], 4'b0000};
    else
      mstat = MSTAT_IDLE;
  end

  always_comb begin
    unique case (bus_addr)
      A_DATA:  bus_rdata = divsel ? div_q[BYTE_W-1:0] : rbr;
      A_IEN:   bus_rdata = divsel ? div_q[DIV_W-1:BYTE_W]
                                  : {{(BYTE_W-IEN_W){1'b0}}, ien_q};
      A_IDENT: bus_rdata = ident;
      A_LCTL:  bus_rdata = lctl_q;
      A_MCTL:  bus_rdata = {{(BYTE_W-MCTL_W){1'b0}}, mctl_q};
      A_LSTAT: bus_rdata = lstat;
      A_MSTAT: bus_rdata = mstat;
      default: bus_rdata = scr_q;
    endcase
  end

  assign divisor    = div_q;
  assign line_ctrl  = lctl_q;
  assign modem_ctrl = mctl_q;
endmodule

// File: rtl/sio_regblock_chk.sv
module sio_regblock_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        irq,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic        rx_brk,
  input logic [7:0]  line_ctrl,
  input logic [4:0]  modem_ctrl
);
  logic thr_write;
  assign thr_write = bus_sel && bus_wr && bus_addr == 3'd0 && !line_ctrl[7];

  a_r4_irq_matches_ident: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 3'd2) |-> (irq == (bus_rdata != 8'h01)));

  a_r2_ien_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 3'd1 && !line_ctrl[7]) |-> (bus_rdata[7:4] == 4'h0));

  a_r11_thr_presents: assert property (@(posedge clk) disable iff (!rst_n)
    thr_write |=> (tx_valid && tx_data == $past(bus_wdata)));

  a_r11_tx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !thr_write) |=> (tx_valid && $stable(tx_data)));

  a_r6_full_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_ready);

  a_r8_break_fills: assert property (@(posedge clk) disable iff (!rst_n)
    rx_brk |=> !rx_ready);

  a_r9_loop_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 3'd6 && modem_ctrl[4]) |-> (bus_rdata[3:0] == 4'h0));
endmodule

bind sio_regblock sio_regblock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_brk(rx_brk),
  .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl)
);

// File: tb/sio_regblock_tb.sv
`timescale 1ns/1ps
module sio_regblock_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq, tx_valid, rx_ready;
  logic tx_ready = 0, rx_valid = 0, rx_brk = 0;
  logic [7:0] tx_data, rx_data = '0, line_ctrl;
  logic [15:0] divisor;
  logic [4:0] modem_ctrl;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sio_regblock u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_brk(rx_brk), .divisor(divisor), .line_ctrl(line_ctrl),
    .modem_ctrl(modem_ctrl)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 chk(tag, {8'h0, bus_rdata}, {8'h0, exp});
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic pulse_rx(logic [7:0] d, logic brk);
    @(negedge clk);
    rx_valid = ~brk; rx_brk = brk; rx_data = d;
    @(posedge clk); #1;
    rx_valid = 0; rx_brk = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10 reset state
    @(negedge clk); #1;
    chk("R10 irq", irq, 0);
    chk("R10 tx_valid", tx_valid, 0);
    chk("R10 rx_ready", rx_ready, 1);
    rd(3'd5, 8'h60, "R10 lstat");
    rd(3'd2, 8'h01, "R10 ident");
    rd(3'd6, 8'hB0, "R10 mstat");

    // R12 scratch sweep, ignored writes
    for (int v = 0; v < 256; v++) begin
      wr(3'd7, v[7:0]);
      rd(3'd7, v[7:0], "R12 scratch");
    end
    wr(3'd2, 8'hFF); wr(3'd5, 8'h00); wr(3'd6, 8'h0F);
    rd(3'd2, 8'h01, "R12 ident after write");
    rd(3'd5, 8'h60, "R12 lstat after write");
    rd(3'd6, 8'hB0, "R12 mstat after write");
    rd(3'd7, 8'hFF, "R12 scratch kept");

    // R9 modem control sweep with loopback mapping
    for (int v = 0; v < 64; v++) begin
      logic [7:0] m, e;
      m = v[7:0] | 8'hC0;
      wr(3'd4, m);
      rd(3'd4, m & 8'h1F, "R9 mctl");
      if (m[4]) e = {m[3], m[2], m[0], m[1], 4'h0};
      else e = 8'hB0;
      rd(3'd6, e, "R9 mstat");
      @(negedge clk); #1 chk("R9 pins", {11'h0, modem_ctrl}, {11'h0, m[4:0]});
    end

    // R1 divisor access
    wr(3'd3, 8'h83);
    rd(3'd3, 8'h83, "R1 lctl");
    wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    @(negedge clk); #1;
    chk("R1 divisor pins", divisor, 16'h1234);
    chk("R1 no tx start", tx_valid, 0);
    chk("R1 line_ctrl pins", {8'h0, line_ctrl}, 16'h0083);
    rd(3'd0, 8'h34, "R1 div lo");
    rd(3'd1, 8'h12, "R1 div hi");
    wr(3'd3, 8'h03);
    rd(3'd1, 8'h00, "R1 ien visible again");

    // R2 enable sweep: upper bits dropped
    for (int v = 0; v < 256; v += 17) begin
      wr(3'd1, v[7:0]);
      rd(3'd1, v[7:0] & 8'h0F, "R2 ien mask");
    end

    // R3/R4/R5 priority sweep over enables and data-ready
    for (int d = 0; d < 2; d++) begin
      if (d == 1) pulse_rx(8'h5A, 0);
      for (int v = 0; v < 16; v++) begin
        logic [7:0] e;
        wr(3'd1, v[7:0]);
        e = (d == 1 && v[0]) ? 8'h04 : (v[1] ? 8'h02 : 8'h01);
        @(negedge clk); #1 chk("R4 irq", irq, e != 8'h01);
        rd(3'd2, e, "R3 ident");
        if (e == 8'h02) rd(3'd2, 8'h01, "R5 pending cleared");
      end
    end
    rd(3'd0, 8'h5A, "R7 rbr");
    rd(3'd5, 8'h60, "R7 dr cleared");

    // R6 accept only while empty
    pulse_rx(8'h3C, 0);
    @(negedge clk); #1 chk("R6 ready low", rx_ready, 0);
    pulse_rx(8'hC3, 0);
    rd(3'd5, 8'h61, "R6 lstat dr");
    rd(3'd0, 8'h3C, "R6 byte kept");
    @(negedge clk); #1 chk("R7 ready back", rx_ready, 1);

    // R8 break
    pulse_rx(8'hEE, 1);
    rd(3'd5, 8'h71, "R8 lstat");
    rd(3'd0, 8'h00, "R8 rbr zero");
    rd(3'd5, 8'h60, "R7 bi dr cleared");

    // R11 transmit path
    wr(3'd1, 8'h02);
    rd(3'd2, 8'h02, "R2 pending on ien write");
    wr(3'd0, 8'hA5);
    @(negedge clk); #1;
    chk("R11 tx_valid", tx_valid, 1);
    chk("R11 tx_data", {8'h0, tx_data}, 16'h00A5);
    chk("R11 irq low", irq, 0);
    rd(3'd5, 8'h00, "R11 lstat busy");
    wr(3'd1, 8'h02);
    rd(3'd2, 8'h01, "R2 no pending while busy");
    @(negedge clk); tx_ready = 1;
    @(posedge clk); #1 tx_ready = 0;
    @(negedge clk); #1;
    chk("R11 tx_valid drop", tx_valid, 0);
    chk("R11 irq", irq, 1);
    rd(3'd5, 8'h60, "R11 lstat empty");
    rd(3'd2, 8'h02, "R11 ident");
    rd(3'd2, 8'h01, "R5 clear");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule